// File: doc/BRIEF.md
# Watchdog Countdown Timer with Keyed Restart

This block guards a system against software that has stopped making progress. Software programs a reload value and turns the block on. A down-counter then decrements once for every cycle in which the tick input is high. To keep the system alive, software must write a fixed key to the restart register often enough, and each accepted write refills the counter. If the counter runs out, a sticky expiry flag is set. Each of two control bits then decides whether the block raises a one-cycle system reset request, a level interrupt, or both.

The block sits behind a plain register port with valid, write, address and 32-bit data signals. Every access is one whole word, and read data comes back combinationally from the address. The sequencing lives in one state machine with three states. ST_IDLE means disabled. ST_RUN means counting. ST_EXPIRED means enabled but stopped at zero. The transitions are:

- ST_IDLE to ST_RUN when the enable bit is written from 0 to 1. This loads the counter.
- ST_RUN to ST_EXPIRED on a tick while the count is 1 or less.
- ST_RUN to ST_RUN on an accepted restart. This reloads the counter.
- ST_EXPIRED to ST_RUN on an accepted restart.
- ST_RUN or ST_EXPIRED to ST_IDLE when the enable bit is written to 0.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control reads 0, status reads 0, the load register reads 0x03EF1480, and irq and rst_req are low.
- R2: Word offset 0x1C reads the constant 0x00010601. Offset 0x18, any address with bits above bit 4 set, and any address whose two lowest bits are not 00 all read 0, and writes to them change nothing.
- R3: Offset 0x04 is the load register, read and written as a full 32-bit word. While the block is disabled, a read of offset 0x00 returns the load value.
- R4: Offset 0x0C is control, and it reads back bits [2:0] as written. Bit 0 is enable, bit 1 is the reset-request enable and bit 2 is the interrupt enable. When bit 0 is written from 0 to 1, the counter is loaded from the load register. Writing 1 to bit 0 while it is already 1 does not reload.
- R5: While the block is enabled and not expired, each clock with tick_en high decrements the counter by 1. A read of offset 0x00 returns the live count.
- R6: A tick that arrives while the count is 1 or less is an expiry. The counter becomes 0 and holds there, and status bit 0 (offset 0x10) is set.
- R7: A write of exactly 0x00005AB9 to offset 0x08 while the block is enabled reloads the counter from the load register and resumes counting. Any other value, or any write while disabled, is ignored.
- R8: Writing 0 to control bit 0 stops the counter, and reads of offset 0x00 then return the load value. Enabling again reloads the counter.
- R9: On an expiry with control bit 1 set, rst_req is high for exactly the one cycle that follows the expiring clock edge.
- R10: irq is high whenever status bit 0 and control bit 2 are both set. It stays high until status is cleared.
- R11: Writing 1 to bit 0 of offset 0x14 clears status bit 0, and writing 0 there does nothing. An expiry in the same cycle as a clear leaves the status set.
- R12: If a restart or a disable is accepted in the same cycle as the final tick, there is no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter decrement strobe |
| bus_valid | input | 1 | An access is present this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | Level interrupt on expiry |

## Verification
Suppose the state machine disagrees with the enable bit, or the counter steps wrongly. The next read of offset 0x00 then returns the wrong value in the same cycle, because read data is combinational. A lost or extra expiry shows up at once, on the clock edge where it happens. Status, irq and the one-cycle rst_req pulse all go wrong together. A status flag that is not sticky, or a mis-decoded key, stays visible on irq until the next write to the status-clear register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_EXPIRED = 2'd2
    } wd_state_e;

    localparam int CTRL_W = 3;

    localparam logic [2:0] IDX_COUNT   = 3'd0;
    localparam logic [2:0] IDX_LOAD    = 3'd1;
    localparam logic [2:0] IDX_RESTART = 3'd2;
    localparam logic [2:0] IDX_CTRL    = 3'd3;
    localparam logic [2:0] IDX_STATUS  = 3'd4;
    localparam logic [2:0] IDX_CLEAR   = 3'd5;
    localparam logic [2:0] IDX_REV     = 3'd7;
endpackage

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          en_rise,
    input  logic          dis,
    input  logic          restart_ok,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          expire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    wd_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_rise) begin
                    state_d = ST_RUN;
                    cnt_d   = load_val;
                end
            end
            ST_RUN: begin
                if (dis) begin
                    state_d = ST_IDLE;
                end else if (restart_ok) begin
                    cnt_d = load_val;
                end else if (tick_en) begin
                    if (cnt_q <= ONE) begin
                        cnt_d   = '0;
                        state_d = ST_EXPIRED;
                        expire  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            ST_EXPIRED: begin
                if (dis) begin
                    state_d = ST_IDLE;
                end else if (restart_ok) begin
                    state_d = ST_RUN;
                    cnt_d   = load_val;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign count = cnt_q;

    assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick_en && cnt_q > ONE && !restart_ok && !dis)
        |=> (cnt_q == $past(cnt_q) - ONE));

    assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED && !restart_ok && !dis) |=> (cnt_q == '0));

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_ok && !dis) |=> (cnt_q == $past(load_val)));

    assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (state_q == ST_IDLE));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          DW         = 32,
    parameter int          AW         = 8,
    parameter logic [31:0] LOAD_RESET = 32'h03EF1480,
    parameter logic [31:0] REVISION   = 32'h00010601,
    parameter logic [31:0] KEY        = 32'h00005AB9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] count,
    input  logic          expire,
    output logic          en_rise,
    output logic          dis,
    output logic          restart_ok,
    output logic [DW-1:0] load_val,
    output logic          rst_req,
    output logic          irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DW-1:0]     load_q;
    logic              status_q;
    logic              rst_req_q;

    logic       in_win, wr;
    logic [2:0] idx;
    logic       wr_load, wr_ctrl, wr_rst, wr_clr;

    assign in_win  = (bus_addr[AW-1:5] == '0) && (bus_addr[1:0] == 2'b00);
    assign idx     = bus_addr[4:2];
    assign wr      = bus_valid && bus_write && in_win;
    assign wr_load = wr && (idx == IDX_LOAD);
    assign wr_ctrl = wr && (idx == IDX_CTRL);
    assign wr_rst  = wr && (idx == IDX_RESTART);
    assign wr_clr  = wr && (idx == IDX_CLEAR);

    assign en_rise    = wr_ctrl && bus_wdata[0] && !ctrl_q[0];
    assign dis        = wr_ctrl && !bus_wdata[0];
    assign restart_ok = wr_rst && (bus_wdata == DW'(KEY)) && ctrl_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            load_q    <= DW'(LOAD_RESET);
            status_q  <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (wr_load) load_q <= bus_wdata;
            if (expire)
                status_q <= 1'b1;
            else if (wr_clr && bus_wdata[0])
                status_q <= 1'b0;
            rst_req_q <= expire && ctrl_q[1];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            unique case (idx)
                IDX_COUNT:  bus_rdata = ctrl_q[0] ? count : load_q;
                IDX_LOAD:   bus_rdata = load_q;
                IDX_CTRL:   bus_rdata = DW'(ctrl_q);
                IDX_STATUS: bus_rdata = DW'(status_q);
                IDX_REV:    bus_rdata = DW'(REVISION);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign load_val = load_q;
    assign rst_req  = rst_req_q;
    assign irq      = status_q && ctrl_q[2];

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_q |=> !rst_req_q);

    assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status_q);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !(wr_clr && bus_wdata[0])) |=> status_q);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int          DW         = 32,
    parameter int          AW         = 8,
    parameter logic [31:0] LOAD_RESET = 32'h03EF1480,
    parameter logic [31:0] REVISION   = 32'h00010601,
    parameter logic [31:0] KEY        = 32'h00005AB9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_req,
    output logic          irq
);
    logic          en_rise, dis, restart_ok, expire;
    logic [DW-1:0] load_val, count;

    wdog_regs #(
        .DW(DW), .AW(AW), .LOAD_RESET(LOAD_RESET),
        .REVISION(REVISION), .KEY(KEY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .expire(expire),
        .en_rise(en_rise), .dis(dis), .restart_ok(restart_ok),
        .load_val(load_val), .rst_req(rst_req), .irq(irq)
    );

    wdog_core #(.CW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .en_rise(en_rise), .dis(dis), .restart_ok(restart_ok),
        .load_val(load_val), .count(count), .expire(expire)
    );
endmodule

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    wdog_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rst_req(rst_req), .irq(irq)
    );

    // bench reference, built from the requirements
    logic [2:0]  m_ctrl;
    logic [31:0] m_load, m_cnt;
    logic        m_stop, m_stat, m_rst;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 3'd0; m_load = 32'h03EF1480; m_cnt = 32'd0;
            m_stop = 1'b0; m_stat = 1'b0; m_rst = 1'b0;
        end else begin
            bit ok, wr, restart, disw, enr, exp_now;
            logic [2:0] ix;
            ok      = (bus_addr[7:5] == 3'd0) && (bus_addr[1:0] == 2'b00);
            ix      = bus_addr[4:2];
            wr      = bus_valid && bus_write && ok;
            restart = wr && ix == 3'd2 && bus_wdata == 32'h00005AB9 && m_ctrl[0];
            disw    = wr && ix == 3'd3 && !bus_wdata[0];
            enr     = wr && ix == 3'd3 && bus_wdata[0] && !m_ctrl[0];
            exp_now = 1'b0;
            if (enr) begin
                m_cnt = m_load; m_stop = 1'b0;
            end else if (m_ctrl[0] && !disw) begin
                if (restart) begin
                    m_cnt = m_load; m_stop = 1'b0;
                end else if (tick_en && !m_stop) begin
                    if (m_cnt <= 32'd1) begin
                        m_cnt = 32'd0; m_stop = 1'b1; exp_now = 1'b1;
                    end else begin
                        m_cnt = m_cnt - 32'd1;
                    end
                end
            end
            if (disw) m_stop = 1'b0;
            m_rst = exp_now && m_ctrl[1];
            if (exp_now) m_stat = 1'b1;
            else if (wr && ix == 3'd5 && bus_wdata[0]) m_stat = 1'b0;
            if (wr && ix == 3'd3) m_ctrl = bus_wdata[2:0];
            if (wr && ix == 3'd1) m_load = bus_wdata;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a[7:5] != 3'd0 || a[1:0] != 2'b00) return 32'd0;
        case (a[4:2])
            3'd0: return m_ctrl[0] ? m_cnt : m_load;
            3'd1: return m_load;
            3'd3: return {29'd0, m_ctrl};
            3'd4: return {31'd0, m_stat};
            3'd7: return 32'h00010601;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a[7:5] != 3'd0 || a[1:0] != 2'b00) return "R2";
        case (a[4:2])
            3'd0: return "R5";
            3'd1: return "R3";
            3'd3: return "R4";
            3'd4: return "R11";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input bit w, input logic [7:0] a,
                        input logic [31:0] d, input bit t);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; tick_en = t;
        @(negedge clk);
        chk(tag_of(a), bus_rdata, exp_rd(a));
        chk("R10 irq", {31'd0, irq}, {31'd0, m_stat && m_ctrl[2]});
        chk("R9 rst_req", {31'd0, rst_req}, {31'd0, m_rst});
    endtask

    task automatic rd(input logic [7:0] a, input bit t);
        step(1'b1, 1'b0, a, 32'd0, t);
    endtask

    task automatic wrt(input logic [7:0] a, input logic [31:0] d, input bit t);
        step(1'b1, 1'b1, a, d, t);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 constants, R3 counter read while disabled
        rd(8'h0C, 0); chk("R1 ctrl reset", bus_rdata, 32'd0);
        chk("R1 irq low", {31'd0, irq}, 32'd0);
        chk("R1 rst_req low", {31'd0, rst_req}, 32'd0);
        rd(8'h10, 0); chk("R1 status reset", bus_rdata, 32'd0);
        rd(8'h04, 0); chk("R1 load reset", bus_rdata, 32'h03EF1480);
        rd(8'h00, 0); chk("R3 counter shows load", bus_rdata, 32'h03EF1480);
        rd(8'h1C, 0); chk("R2 revision", bus_rdata, 32'h00010601);
        rd(8'h18, 0); chk("R2 int length zero", bus_rdata, 32'd0);

        // R4 enable loads, R5 decrement, R6/R9/R10 expiry
        wrt(8'h04, 32'd3, 0);
        rd(8'h04, 0); chk("R3 load write", bus_rdata, 32'd3);
        wrt(8'h0C, 32'd7, 0); chk("R4 ctrl readback", bus_rdata, 32'd7);
        rd(8'h00, 0); chk("R4 enable loads", bus_rdata, 32'd3);
        rd(8'h00, 1); chk("R5 dec 3->2", bus_rdata, 32'd2);
        rd(8'h00, 1); chk("R5 dec 2->1", bus_rdata, 32'd1);
        rd(8'h00, 1); chk("R6 expire to 0", bus_rdata, 32'd0);
        chk("R9 pulse high", {31'd0, rst_req}, 32'd1);
        chk("R10 irq high", {31'd0, irq}, 32'd1);
        rd(8'h10, 1); chk("R6 status set", bus_rdata, 32'd1);
        chk("R9 pulse one cycle", {31'd0, rst_req}, 32'd0);
        rd(8'h00, 1); chk("R6 holds at zero", bus_rdata, 32'd0);

        // R11 status clear
        wrt(8'h14, 32'd0, 0);
        rd(8'h10, 0); chk("R11 clear with 0 ignored", bus_rdata, 32'd1);
        wrt(8'h14, 32'd1, 0);
        rd(8'h10, 0); chk("R11 cleared", bus_rdata, 32'd0);
        chk("R10 irq drops", {31'd0, irq}, 32'd0);

        // R7 keyed restart
        wrt(8'h08, 32'h00005AB8, 0);
        rd(8'h00, 0); chk("R7 wrong key ignored", bus_rdata, 32'd0);
        wrt(8'h08, 32'h00005AB9, 0);
        rd(8'h00, 0); chk("R7 key reloads", bus_rdata, 32'd3);

        // R12 restart on final tick
        rd(8'h00, 1); rd(8'h00, 1);
        chk("R5 count at 1", bus_rdata, 32'd1);
        wrt(8'h08, 32'h00005AB9, 1);
        rd(8'h00, 0); chk("R12 restart beats tick", bus_rdata, 32'd3);
        rd(8'h10, 0); chk("R12 no expiry", bus_rdata, 32'd0);

        // R8 disable and re-enable
        wrt(8'h0C, 32'd0, 0);
        rd(8'h00, 0); chk("R8 disabled shows load", bus_rdata, 32'd3);
        wrt(8'h04, 32'd5, 0);
        wrt(8'h08, 32'h00005AB9, 1);
        rd(8'h00, 1); chk("R8 stopped", bus_rdata, 32'd5);
        rd(8'h10, 1); chk("R8 no expiry while off", bus_rdata, 32'd0);
        wrt(8'h0C, 32'd1, 0);
        rd(8'h00, 0); chk("R8 re-enable reloads", bus_rdata, 32'd5);
        rd(8'h00, 1); chk("R5 dec 5->4", bus_rdata, 32'd4);
        wrt(8'h0C, 32'd1, 0);
        rd(8'h00, 0); chk("R4 no reload when already on", bus_rdata, 32'd4);

        // R2 ignored writes
        wrt(8'h18, 32'hFFFFFFFF, 0);
        rd(8'h18, 0); chk("R2 int length write ignored", bus_rdata, 32'd0);
        wrt(8'h44, 32'd0, 0);
        rd(8'h04, 0); chk("R2 unmapped write ignored", bus_rdata, 32'd5);
        wrt(8'h06, 32'd0, 0);
        rd(8'h04, 0); chk("R2 misaligned write ignored", bus_rdata, 32'd5);

        // constrained random mix against the bench reference
        for (int i = 0; i < 6000; i++) begin
            int op;
            bit t;
            logic [7:0] a;
            op = $urandom % 12;
            t  = ($urandom % 3) != 0;
            a  = {3'd0, 3'($urandom % 8), 2'b00};
            if (($urandom % 16) == 0) a = 8'($urandom);
            case (op)
                0:  wrt(8'h04, 32'($urandom % 8), t);
                1:  wrt(8'h0C, 32'($urandom % 8), t);
                2:  wrt(8'h08, 32'h00005AB9, t);
                3:  wrt(8'h08, 32'h00005AB9 ^ (32'd1 << ($urandom % 32)), t);
                4:  wrt(8'h14, 32'($urandom % 2), t);
                5:  wrt(a, 32'($urandom), t);
                default: rd(a, t);
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule